// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit

This unit is the datapath core of a small register machine. It takes two operands and a four-bit opcode, and it produces an eight-bit result and a flag that shows an all-zero result. It performs bitwise AND, OR and XOR, a ripple-carry ADD, a unary NOT and a bidirectional SHIFT. The second operand of SHIFT is a signed count: a positive count moves the bits toward bit 0, and a negative count moves them toward the top bit.

There is no subtract operation. Software forms a subtraction by applying NOT and then ADD. The control-unit opcodes for memory transfer, branching and halting give a zero result here, because the rest of the machine acts on them. Both outputs are registered, so each result appears one clock after its inputs are applied.

Top module: `toy_alu8`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0x00 and `zero` becomes 1. This holds whatever the operand and opcode inputs are.
- R2: The bitwise opcodes are AND = 4'b1001, OR = 4'b1000 and XOR = 4'b0111. Each gives the bitwise combination of `op_a` and `op_b`.
- R3: ADD (4'b0110) gives the low eight bits of `op_a + op_b`. The carry out of the top bit is discarded.
- R4: NOT (4'b0010) gives the bitwise inverse of `op_a`. The value of `op_b` has no effect on the result.
- R5: SHIFT (4'b0001) with a non-negative `op_b` between 0 and 7 shifts `op_a` toward bit 0 by that count and fills the vacated top bits with zeros. A count of 0 returns `op_a` unchanged.
- R6: SHIFT with `op_b` between -1 and -7 (two's complement) shifts `op_a` toward bit 7 by the count's magnitude and fills the vacated low bits with zeros.
- R7: SHIFT with a count of magnitude 8 or more gives 0x00 in either direction. This includes -128 (0x80).
- R8: Every opcode other than the six above gives 0x00. This covers 4'b0000 and 4'b0011 through 4'b0101 and 4'b1010 through 4'b1111.
- R9: `zero` is 1 exactly when the registered `result` is 0x00.
- R10: Outputs change only at a rising clock edge. The result for the inputs present at an edge appears after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand; signed shift count for SHIFT |
| opcode | input | 4 | Operation select |
| result | output | 8 | Registered result |
| zero | output | 1 | Registered flag for an all-zero result |

## Verification
The properties assume that the opcode and both operands are stable and known at each rising edge. They also assume that reset is low in the cycle the inputs are sampled and in the cycle that follows. The bench changes inputs only on falling edges and reads outputs on falling edges. It keeps reset low through every vector, except in the reset tests, where it looks only at the cleared state. The shift counts it applies cover both signs, zero, both limits of the legal range and values beyond that range, so the properties for far shifts have antecedents that actually occur.

// File: rtl/toy_alu8_pkg.sv
package toy_alu8_pkg;
  typedef enum logic [3:0] {
    OPC_HALT   = 4'b0000,
    OPC_SHIFT  = 4'b0001,
    OPC_NOT    = 4'b0010,
    OPC_BRANCH = 4'b0011,
    OPC_STORE  = 4'b0100,
    OPC_LOAD   = 4'b0101,
    OPC_ADD    = 4'b0110,
    OPC_XOR    = 4'b0111,
    OPC_OR     = 4'b1000,
    OPC_AND    = 4'b1001
  } alu_opc_e;
endpackage

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  // One full adder per column; carry out of the top column is dropped
  for (genvar i = 0; i < W; i++) begin : g_col
    logic half;
    assign half       = a[i] ^ b[i];
    assign sum[i]     = half ^ carry[i];
    assign carry[i+1] = (half & carry[i]) | (a[i] & b[i]);
  end

  logic unused_cout;
  assign unused_cout = carry[W];
endmodule

// File: rtl/alu_signed_shift.sv
module alu_signed_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] LIMIT = W[W-1:0];

  logic         to_left;
  logic [W-1:0] mag;
  logic         too_far;

  assign to_left = cnt[W-1];
  assign mag     = to_left ? (~cnt + ONE) : cnt;
  assign too_far = (mag >= LIMIT);

  always_comb begin
    if (too_far)      y = '0;
    else if (to_left) y = a << mag;
    else              y = a >> mag;
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y_and,
  output logic [W-1:0] y_or,
  output logic [W-1:0] y_xor,
  output logic [W-1:0] y_not
);
  assign y_and = a & b;
  assign y_or  = a | b;
  assign y_xor = a ^ b;
  assign y_not = ~a;
endmodule

// File: rtl/toy_alu8.sv
module toy_alu8
  import toy_alu8_pkg::*;
#(
  parameter int W   = 8,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [OPW-1:0] opcode,
  output logic [W-1:0]   result,
  output logic           zero
);
  logic [W-1:0] s_and, s_or, s_xor, s_not, s_add, s_shf;
  logic [W-1:0] res_d;

  alu_bitwise #(.W(W)) u_bitwise (
    .a(op_a), .b(op_b),
    .y_and(s_and), .y_or(s_or), .y_xor(s_xor), .y_not(s_not)
  );

  alu_ripple_add #(.W(W)) u_add (
    .a(op_a), .b(op_b), .sum(s_add)
  );

  alu_signed_shift #(.W(W)) u_shift (
    .a(op_a), .cnt(op_b), .y(s_shf)
  );

  always_comb begin
    unique case (opcode)
      OPC_AND:   res_d = s_and;
      OPC_OR:    res_d = s_or;
      OPC_XOR:   res_d = s_xor;
      OPC_ADD:   res_d = s_add;
      OPC_NOT:   res_d = s_not;
      OPC_SHIFT: res_d = s_shf;
      default:   res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= res_d;
      zero   <= (res_d == '0);
    end
  end
endmodule

// File: rtl/toy_alu8_chk.sv
module toy_alu8_chk #(
  parameter int W   = 8,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [OPW-1:0] opcode,
  input logic [W-1:0]   result,
  input logic           zero
);
  localparam int LIM = W;

  logic is_legal;
  assign is_legal = (opcode == 4'b1001) || (opcode == 4'b1000) ||
                    (opcode == 4'b0111) || (opcode == 4'b0110) ||
                    (opcode == 4'b0010) || (opcode == 4'b0001);

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  // R8
  illegal_op_chk: assert property (@(posedge clk) disable iff (rst)
    !is_legal |=> (result == '0));

  // R4
  not_op_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'b0010) |=> (result == ~$past(op_a)));

  // R3
  add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'b0110) |=> (result == W'($past(op_a) + $past(op_b))));

  // R7
  far_shift_chk: assert property (@(posedge clk) disable iff (rst)
    ((opcode == 4'b0001) && (($signed(op_b) >= LIM) || ($signed(op_b) <= -LIM)))
      |=> (result == '0));

  // R2
  and_op_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'b1001) |=> (result == ($past(op_a) & $past(op_b))));
endmodule

bind toy_alu8 toy_alu8_chk #(.W(W), .OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
  .opcode(opcode), .result(result), .zero(zero)
);

// File: tb/toy_alu8_bench.sv
`timescale 1ns/1ps
module toy_alu8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_a = 8'h00;
  logic [7:0] op_b = 8'h00;
  logic [3:0] opcode = 4'h0;
  logic [7:0] result;
  logic       zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  toy_alu8 u_toy_alu8 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .result(result), .zero(zero)
  );

  // {opcode, op_a, op_b, expected}
  localparam int NV = 20;
  localparam logic [27:0] VEC [0:NV-1] = '{
    {4'h9, 8'hB6, 8'h68, 8'h20},  // R2 AND
    {4'h8, 8'hB6, 8'h68, 8'hFE},  // R2 OR
    {4'h7, 8'hB6, 8'h68, 8'hDE},  // R2 XOR
    {4'h6, 8'h07, 8'hFD, 8'h04},  // R3 carry dropped
    {4'h6, 8'h64, 8'h99, 8'hFD},  // R3
    {4'h6, 8'h01, 8'hFF, 8'h00},  // R3 wraps to zero
    {4'h2, 8'h68, 8'hFF, 8'h97},  // R4
    {4'h2, 8'h68, 8'h00, 8'h97},  // R4 op_b ignored
    {4'h1, 8'hB6, 8'h01, 8'h5B},  // R5
    {4'h1, 8'h80, 8'h07, 8'h01},  // R5 sign bit to bit 0
    {4'h1, 8'hB6, 8'h00, 8'hB6},  // R5 zero count
    {4'h1, 8'hB6, 8'hFE, 8'hD8},  // R6 -2
    {4'h1, 8'h01, 8'hF9, 8'h80},  // R6 -7
    {4'h1, 8'hB6, 8'h08, 8'h00},  // R7 +8
    {4'h1, 8'hB6, 8'hF8, 8'h00},  // R7 -8
    {4'h1, 8'hFF, 8'h80, 8'h00},  // R7 -128
    {4'h5, 8'hFF, 8'hFF, 8'h00},  // R8 LOAD
    {4'h3, 8'hFF, 8'h01, 8'h00},  // R8 BRANCH
    {4'h0, 8'hFF, 8'hFF, 8'h00},  // R8 HALT
    {4'hF, 8'hFF, 8'hFF, 8'h00}   // R8 unused code
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset dominates nonzero inputs
    opcode = 4'h9; op_a = 8'hFF; op_b = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 result", result, 8'h00);
    check("R1 zero", {7'b0, zero}, 8'h01);

    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      opcode = VEC[i][27:24];
      op_a   = VEC[i][23:16];
      op_b   = VEC[i][15:8];
      @(negedge clk);
      check($sformatf("vector %0d", i), result, VEC[i][7:0]);
      // R9
      check($sformatf("R9 vector %0d", i), {7'b0, zero}, {7'b0, VEC[i][7:0] == 8'h00});
    end

    // R10: new inputs do not reach outputs before the edge
    opcode = 4'h2; op_a = 8'h00; op_b = 8'h12;
    #1;
    check("R10 before edge", result, 8'h00);
    check("R10 zero before edge", {7'b0, zero}, 8'h01);
    @(negedge clk);
    check("R10 after edge", result, 8'hFF);
    check("R9 after edge", {7'b0, zero}, 8'h00);

    // R1: reset mid-run clears a nonzero result
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run result", result, 8'h00);
    check("R1 mid-run zero", {7'b0, zero}, 8'h01);
    rst = 1'b0;
    opcode = 4'h1; op_a = 8'h40; op_b = 8'hFF;  // R6 -1
    @(negedge clk);
    check("R6 minus one", result, 8'h80);

    done = 1'b1;
    finish_run();
  end
endmodule